// File: doc/BRIEF.md
# Region-Splitting Access Checker

This block sits between a load/store or fetch unit and the memory system. It accepts one memory request (a 32-bit start address, a size of 1, 2, 4 or 8 bytes, and a kind of load, store or instruction fetch). It breaks the request into one sub-access for each 32-byte aligned region the bytes touch, so an access yields one or two parts. Each part's attributes come from its own lookup. That lookup uses a four-entry region table when the table is enabled, and a fixed default address map when it is not or when no entry matches.

Before any part is issued, the block checks the whole request. A load or store that is unaligned and touches Device memory in any part raises an unaligned fault. A fetch that touches an execute-never region in any part raises an execute-never fault. A faulting request issues nothing, and one fault is reported carrying the start address of the first faulting part. Otherwise the parts go out in ascending address order on a valid/ready handshake. Each part carries its start address, byte count, a last flag and a Device flag. The address space wraps, so a request running past 0xFFFFFFFF continues at 0x00000000.

The region table is supplied on configuration ports. Entry g occupies bits [g*27 +: 27] of the base and limit vectors. Base and limit are inclusive region numbers, meaning address bits [31:5].

Top module: `mem_split_unit`

## Requirements
- R1: Reset state. After reset, req_ready_o is 1 and both sub_valid_o and fault_o are 0.
- R2: Single-region requests. req_size_i codes 0/1/2/3 mean 1/2/4/8 bytes. req_kind_i codes are 0 = load, 1 = store and 2 = fetch. A request whose bytes lie in one 32-byte aligned region, and which does not fault, is issued as one sub-access. That sub-access carries the request address, the full byte count, sub_last_o = 1 and the request kind.
- R3: Two-region requests. A request that crosses a 32-byte boundary is issued as two sub-accesses. The first runs from the request address to the end of its region with sub_last_o = 0. The second starts at the next region's base, carries the remaining bytes and has sub_last_o = 1.
- R4: Wrap. When the second region lies past 0xFFFFFFFF, the second sub-access starts at 0x00000000.
- R5: Per-part attributes. Each part gets its own attribute lookup. sub_device_o, and every fault decision for a part, use that part's own result.
- R6: Region table priority. With tbl_en_i = 1, the lowest-numbered entry wins among those that are enabled and whose base ≤ address[31:5] ≤ limit. A disabled entry never matches. An address that no entry matches takes its attributes from the default map.
- R7: Default map. With tbl_en_i = 0, addresses below 0x40000000 are Normal and executable, and all other addresses are Device and execute-never.
- R8: Unaligned faults. An access is aligned when its address is a multiple of its size. An unaligned load or store with any part in Device memory issues no sub-access. It produces a one-cycle fault_o pulse with fault_code_o = 1 and fault_addr_o equal to the start address of the first Device part. An aligned Device load or store is issued normally.
- R9: Device fetches. A fetch whose parts are Device but not execute-never is issued, with sub_device_o = 1 on those parts.
- R10: Execute-never faults. A fetch with any part in an execute-never region issues no sub-access. It produces a one-cycle fault_o pulse with fault_code_o = 2 and fault_addr_o equal to the start address of the first execute-never part.
- R11: Handshake. req_ready_o stays 0 from request acceptance until the last sub-access is accepted or the fault is reported. While sub_valid_o = 1 and sub_ready_i = 0, the sub-access outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_en_i | input | 1 | Use region table (1) or default map only (0) |
| rgn_en_i | input | 4 | Per-entry enable |
| rgn_base_i | input | 108 | Entry base region numbers, 27 bits each |
| rgn_limit_i | input | 108 | Entry limit region numbers (inclusive), 27 bits each |
| rgn_dev_i | input | 4 | Per-entry Device type |
| rgn_xn_i | input | 4 | Per-entry execute-never |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_addr_i | input | 32 | Request start address |
| req_size_i | input | 2 | Size code (bytes = 1 << code) |
| req_kind_i | input | 2 | 0 load, 1 store, 2 fetch |
| sub_valid_o | output | 1 | Sub-access valid |
| sub_ready_i | input | 1 | Sub-access accepted |
| sub_addr_o | output | 32 | Sub-access start address |
| sub_bytes_o | output | 4 | Sub-access byte count |
| sub_last_o | output | 1 | Final sub-access of the request |
| sub_device_o | output | 1 | Sub-access targets Device memory |
| sub_kind_o | output | 2 | Kind of the owning request |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_addr_o | output | 32 | Start address of the faulting part |
| fault_code_o | output | 2 | 1 unaligned, 2 execute-never |

## Verification
Aligned single-region requests at several sizes and kinds establish the basic pass-through. Unaligned requests that straddle a boundary, including one ending exactly at a boundary and one past the top of memory, separate correct splitting from wrong byte counts and missed wrap. Requests whose two parts fall into regions with different types (Normal then Device, and executable then execute-never) show whether each part really gets its own lookup and whether the fault reports the right part's address. Overlapping, disabled and unmatched table entries, together with stalls on sub_ready_i, separate priority, fallback and hold behaviour.

// File: rtl/split_pkg.sv
package split_pkg;
  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE      = 2'd0,
    FLT_UNALIGNED = 2'd1,
    FLT_XN        = 2'd2
  } fault_code_e;

  typedef struct packed {
    logic device;
    logic xn;
  } attr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_PART0,
    ST_PART1,
    ST_FAULT
  } seq_state_e;
endpackage

// File: rtl/split_calc.sv
module split_calc #(
  parameter int ADDR_W = 32,
  parameter int RGN_LG = 5,
  parameter int SIZE_W = 2,
  localparam int PG_W  = ADDR_W - RGN_LG,
  localparam int CNT_W = 1 << SIZE_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [ADDR_W-1:0] p0_addr_o,
  output logic [CNT_W-1:0]  p0_bytes_o,
  output logic [ADDR_W-1:0] p1_addr_o,
  output logic [CNT_W-1:0]  p1_bytes_o,
  output logic              two_parts_o,
  output logic              aligned_o
);
  localparam int RGN_BYTES = 1 << RGN_LG;

  logic [CNT_W-1:0]  total;
  logic [ADDR_W-1:0] end_addr;
  logic [RGN_LG:0]   room;

  assign total       = CNT_W'(1) << size_i;
  assign end_addr    = addr_i + ADDR_W'(total) - ADDR_W'(1);
  assign two_parts_o = addr_i[ADDR_W-1:RGN_LG] != end_addr[ADDR_W-1:RGN_LG];
  assign room        = (RGN_LG+1)'(RGN_BYTES) - (RGN_LG+1)'(addr_i[RGN_LG-1:0]);
  assign aligned_o   = (addr_i[CNT_W-1:0] & (total - CNT_W'(1))) == '0;

  assign p0_addr_o  = addr_i;
  assign p0_bytes_o = two_parts_o ? CNT_W'(room) : total;
  // next region base; top region rolls to zero
  assign p1_addr_o  = {addr_i[ADDR_W-1:RGN_LG] + PG_W'(1), {RGN_LG{1'b0}}};
  assign p1_bytes_o = total - p0_bytes_o;
endmodule

// File: rtl/attr_lookup.sv
module attr_lookup import split_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int RGN_LG  = 5,
  parameter int NUM_RGN = 4,
  parameter logic [ADDR_W-1:0] DEF_NORMAL_TOP = 'h4000_0000,
  localparam int PG_W = ADDR_W - RGN_LG
) (
  input  logic [PG_W-1:0]         page_i,
  input  logic                    tbl_en_i,
  input  logic [NUM_RGN-1:0]      rgn_en_i,
  input  logic [NUM_RGN*PG_W-1:0] rgn_base_i,
  input  logic [NUM_RGN*PG_W-1:0] rgn_limit_i,
  input  logic [NUM_RGN-1:0]      rgn_dev_i,
  input  logic [NUM_RGN-1:0]      rgn_xn_i,
  output attr_t                   attr_o
);
  localparam logic [PG_W-1:0] DEF_PAGE = DEF_NORMAL_TOP[ADDR_W-1:RGN_LG];

  logic [NUM_RGN-1:0] match;
  logic               def_dev;

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_match
    assign match[g] = rgn_en_i[g]
                   && page_i >= rgn_base_i[g*PG_W +: PG_W]
                   && page_i <= rgn_limit_i[g*PG_W +: PG_W];
  end

  assign def_dev = page_i >= DEF_PAGE;

  // scan downwards so the lowest matching entry is applied last
  always_comb begin
    attr_o.device = def_dev;
    attr_o.xn     = def_dev;
    if (tbl_en_i) begin
      for (int i = NUM_RGN - 1; i >= 0; i--) begin
        if (match[i]) begin
          attr_o.device = rgn_dev_i[i];
          attr_o.xn     = rgn_xn_i[i];
        end
      end
    end
  end
endmodule

// File: rtl/split_seq.sv
module split_seq import split_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int RGN_LG = 5,
  parameter int SIZE_W = 2,
  localparam int PG_W  = ADDR_W - RGN_LG,
  localparam int CNT_W = 1 << SIZE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [1:0]        req_kind_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [SIZE_W-1:0] cur_size_o,
  input  logic [ADDR_W-1:0] p0_addr_i,
  input  logic [CNT_W-1:0]  p0_bytes_i,
  input  logic [ADDR_W-1:0] p1_addr_i,
  input  logic [CNT_W-1:0]  p1_bytes_i,
  input  logic              two_parts_i,
  input  logic              aligned_i,
  input  attr_t             attr0_i,
  input  attr_t             attr1_i,
  output logic              sub_valid_o,
  input  logic              sub_ready_i,
  output logic [ADDR_W-1:0] sub_addr_o,
  output logic [CNT_W-1:0]  sub_bytes_o,
  output logic              sub_last_o,
  output logic              sub_device_o,
  output logic [1:0]        sub_kind_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic [1:0]        fault_code_o
);
  localparam int RGN_BYTES = 1 << RGN_LG;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, flt_addr_q;
  logic [SIZE_W-1:0] size_q;
  logic [1:0]        kind_q;
  fault_code_e       flt_code_q;
  logic              is_fetch, f0, f1, in_p1, cur_xn;

  assign is_fetch = kind_q == KIND_FETCH;
  assign f0 = is_fetch ? attr0_i.xn : (!aligned_i && attr0_i.device);
  assign f1 = two_parts_i && (is_fetch ? attr1_i.xn : (!aligned_i && attr1_i.device));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_CHECK;
      ST_CHECK: state_d = (f0 || f1) ? ST_FAULT : ST_PART0;
      ST_PART0: if (sub_ready_i) state_d = two_parts_i ? ST_PART1 : ST_IDLE;
      ST_PART1: if (sub_ready_i) state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      size_q     <= '0;
      kind_q     <= '0;
      flt_addr_q <= '0;
      flt_code_q <= FLT_NONE;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        addr_q <= req_addr_i;
        size_q <= req_size_i;
        kind_q <= req_kind_i;
      end
      if (state_q == ST_CHECK) begin
        flt_addr_q <= f0 ? p0_addr_i : p1_addr_i;
        flt_code_q <= is_fetch ? FLT_XN : FLT_UNALIGNED;
      end
    end
  end

  assign cur_addr_o  = addr_q;
  assign cur_size_o  = size_q;
  assign req_ready_o = state_q == ST_IDLE;

  assign in_p1        = state_q == ST_PART1;
  assign sub_valid_o  = (state_q == ST_PART0) || in_p1;
  assign sub_addr_o   = in_p1 ? p1_addr_i : p0_addr_i;
  assign sub_bytes_o  = in_p1 ? p1_bytes_i : p0_bytes_i;
  assign sub_last_o   = in_p1 || !two_parts_i;
  assign sub_device_o = in_p1 ? attr1_i.device : attr0_i.device;
  assign cur_xn       = in_p1 ? attr1_i.xn : attr0_i.xn;
  assign sub_kind_o   = kind_q;

  assign fault_o      = state_q == ST_FAULT;
  assign fault_addr_o = flt_addr_q;
  assign fault_code_o = flt_code_q;

  p_single_region_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o |-> (int'(sub_addr_o[RGN_LG-1:0]) + int'(sub_bytes_o)) <= RGN_BYTES);

  p_last_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o && sub_ready_i && !sub_last_o |=> sub_valid_o && sub_last_o);

  p_next_region_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o && sub_ready_i && !sub_last_o |=>
      sub_addr_o[RGN_LG-1:0] == '0 &&
      sub_addr_o[ADDR_W-1:RGN_LG] == $past(sub_addr_o[ADDR_W-1:RGN_LG]) + PG_W'(1));

  p_dev_aligned_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o && sub_device_o && !is_fetch |-> aligned_i);

  p_fault_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o && req_ready_o);

  p_no_xn_fetch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o && is_fetch |-> !cur_xn);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o && !sub_ready_i |=> sub_valid_o && $stable(sub_addr_o) &&
      $stable(sub_bytes_o) && $stable(sub_last_o) && $stable(sub_device_o));
endmodule

// File: rtl/mem_split_unit.sv
module mem_split_unit import split_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int RGN_LG  = 5,
  parameter int NUM_RGN = 4,
  parameter int SIZE_W  = 2,
  parameter logic [ADDR_W-1:0] DEF_NORMAL_TOP = 'h4000_0000,
  localparam int PG_W  = ADDR_W - RGN_LG,
  localparam int CNT_W = 1 << SIZE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tbl_en_i,
  input  logic [NUM_RGN-1:0]      rgn_en_i,
  input  logic [NUM_RGN*PG_W-1:0] rgn_base_i,
  input  logic [NUM_RGN*PG_W-1:0] rgn_limit_i,
  input  logic [NUM_RGN-1:0]      rgn_dev_i,
  input  logic [NUM_RGN-1:0]      rgn_xn_i,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [SIZE_W-1:0]       req_size_i,
  input  logic [1:0]              req_kind_i,
  output logic                    sub_valid_o,
  input  logic                    sub_ready_i,
  output logic [ADDR_W-1:0]       sub_addr_o,
  output logic [CNT_W-1:0]        sub_bytes_o,
  output logic                    sub_last_o,
  output logic                    sub_device_o,
  output logic [1:0]              sub_kind_o,
  output logic                    fault_o,
  output logic [ADDR_W-1:0]       fault_addr_o,
  output logic [1:0]              fault_code_o
);
  localparam int N_PARTS = 2;

  logic [ADDR_W-1:0] cur_addr;
  logic [SIZE_W-1:0] cur_size;
  logic [ADDR_W-1:0] part_addr  [N_PARTS];
  logic [CNT_W-1:0]  part_bytes [N_PARTS];
  attr_t             part_attr  [N_PARTS];
  logic              two_parts, aligned;

  split_calc #(.ADDR_W(ADDR_W), .RGN_LG(RGN_LG), .SIZE_W(SIZE_W)) u_calc (
    .addr_i      (cur_addr),
    .size_i      (cur_size),
    .p0_addr_o   (part_addr[0]),
    .p0_bytes_o  (part_bytes[0]),
    .p1_addr_o   (part_addr[1]),
    .p1_bytes_o  (part_bytes[1]),
    .two_parts_o (two_parts),
    .aligned_o   (aligned)
  );

  // one independent lookup per region a request can touch
  for (genvar p = 0; p < N_PARTS; p++) begin : g_lookup
    attr_lookup #(
      .ADDR_W(ADDR_W), .RGN_LG(RGN_LG), .NUM_RGN(NUM_RGN), .DEF_NORMAL_TOP(DEF_NORMAL_TOP)
    ) u_lookup (
      .page_i      (part_addr[p][ADDR_W-1:RGN_LG]),
      .tbl_en_i    (tbl_en_i),
      .rgn_en_i    (rgn_en_i),
      .rgn_base_i  (rgn_base_i),
      .rgn_limit_i (rgn_limit_i),
      .rgn_dev_i   (rgn_dev_i),
      .rgn_xn_i    (rgn_xn_i),
      .attr_o      (part_attr[p])
    );
  end

  split_seq #(.ADDR_W(ADDR_W), .RGN_LG(RGN_LG), .SIZE_W(SIZE_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_addr_i   (req_addr_i),
    .req_size_i   (req_size_i),
    .req_kind_i   (req_kind_i),
    .cur_addr_o   (cur_addr),
    .cur_size_o   (cur_size),
    .p0_addr_i    (part_addr[0]),
    .p0_bytes_i   (part_bytes[0]),
    .p1_addr_i    (part_addr[1]),
    .p1_bytes_i   (part_bytes[1]),
    .two_parts_i  (two_parts),
    .aligned_i    (aligned),
    .attr0_i      (part_attr[0]),
    .attr1_i      (part_attr[1]),
    .sub_valid_o  (sub_valid_o),
    .sub_ready_i  (sub_ready_i),
    .sub_addr_o   (sub_addr_o),
    .sub_bytes_o  (sub_bytes_o),
    .sub_last_o   (sub_last_o),
    .sub_device_o (sub_device_o),
    .sub_kind_o   (sub_kind_o),
    .fault_o      (fault_o),
    .fault_addr_o (fault_addr_o),
    .fault_code_o (fault_code_o)
  );

  p_busy_not_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  p_fault_silent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !sub_valid_o && (fault_code_o == FLT_UNALIGNED || fault_code_o == FLT_XN));
endmodule

// File: tb/mem_split_unit_test.sv
module mem_split_unit_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int PG_W = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              tbl_en;
  logic [3:0]        rgn_en;
  logic [4*PG_W-1:0] rgn_base, rgn_limit;
  logic [3:0]        rgn_dev, rgn_xn;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [31:0]       req_addr = '0;
  logic [1:0]        req_size = '0;
  logic [1:0]        req_kind = '0;
  logic              sub_valid;
  logic              sub_ready = 1'b1;
  logic [31:0]       sub_addr;
  logic [3:0]        sub_bytes;
  logic              sub_last, sub_device;
  logic [1:0]        sub_kind;
  logic              fault;
  logic [31:0]       fault_addr;
  logic [1:0]        fault_code;

  mem_split_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .tbl_en_i(tbl_en), .rgn_en_i(rgn_en),
    .rgn_base_i(rgn_base), .rgn_limit_i(rgn_limit), .rgn_dev_i(rgn_dev), .rgn_xn_i(rgn_xn),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_kind_i(req_kind), .sub_valid_o(sub_valid),
    .sub_ready_i(sub_ready), .sub_addr_o(sub_addr), .sub_bytes_o(sub_bytes),
    .sub_last_o(sub_last), .sub_device_o(sub_device), .sub_kind_o(sub_kind),
    .fault_o(fault), .fault_addr_o(fault_addr), .fault_code_o(fault_code)
  );

  // bench copy of the table configuration
  bit          tbl_on;
  bit          m_en  [4];
  logic [26:0] m_base[4];
  logic [26:0] m_lim [4];
  bit          m_dev [4];
  bit          m_xn  [4];

  assign tbl_en = tbl_on;
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      rgn_en[i]                 = m_en[i];
      rgn_dev[i]                = m_dev[i];
      rgn_xn[i]                 = m_xn[i];
      rgn_base[i*PG_W +: PG_W]  = m_base[i];
      rgn_limit[i*PG_W +: PG_W] = m_lim[i];
    end
  end

  typedef struct {
    logic [31:0] addr;
    int          bytes;
    bit          last;
    bit          dev;
    logic [1:0]  kind;
    string       tag;
  } part_t;

  typedef struct {
    logic [31:0] addr;
    logic [1:0]  code;
    string       tag;
  } flt_t;

  part_t exp_parts[$];
  flt_t  exp_flts[$];

  int n_checks = 0;
  int n_errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void ref_attr(input logic [31:0] a, output bit dev, output bit xn);
    bit found = 0;
    dev = (a >= 32'h4000_0000);
    xn  = dev;
    if (tbl_on) begin
      for (int i = 0; i < 4; i++) begin
        if (!found && m_en[i] && a[31:5] >= m_base[i] && a[31:5] <= m_lim[i]) begin
          found = 1;
          dev   = m_dev[i];
          xn    = m_xn[i];
        end
      end
    end
  endfunction

  function automatic void model(input logic [31:0] a, input int sz, input logic [1:0] k,
                                input string tag);
    int          n     = 1 << sz;
    logic [31:0] last  = a + 32'(n) - 32'd1;
    bit          split = a[31:5] != last[31:5];
    logic [31:0] a1    = {a[31:5] + 27'd1, 5'd0};
    int          n0    = split ? 32 - int'(a[4:0]) : n;
    bit          align = (int'(a[3:0]) % n) == 0;
    bit          fetch = (k == 2'd2);
    bit          d0, x0, d1, x1, f0, f1;
    ref_attr(a, d0, x0);
    ref_attr(a1, d1, x1);
    f0 = fetch ? x0 : (!align && d0);
    f1 = split && (fetch ? x1 : (!align && d1));
    if (f0 || f1) begin
      exp_flts.push_back('{f0 ? a : a1, fetch ? 2'd2 : 2'd1, tag});
    end else begin
      exp_parts.push_back('{a, n0, !split, d0, k, tag});
      if (split) exp_parts.push_back('{a1, n - n0, 1'b1, d1, k, tag});
    end
  endfunction

  // cycle monitor, sampled mid-cycle
  bit fault_prev = 0;
  always @(negedge clk) begin
    part_t p;
    flt_t  f;
    if (rst_n) begin
      if (sub_valid) begin
        chk(!req_ready, "R11", "req_ready while issuing", 32'(req_ready), 0);
        if (exp_parts.size() == 0) begin
          chk(0, "R2", "unexpected sub-access", sub_addr, 0);
        end else begin
          p = exp_parts[0];
          chk(sub_addr == p.addr, p.tag, "sub_addr", sub_addr, p.addr);
          chk(int'(sub_bytes) == p.bytes, p.tag, "sub_bytes", 32'(sub_bytes), 32'(p.bytes));
          chk(sub_last == p.last, p.tag, "sub_last", 32'(sub_last), 32'(p.last));
          chk(sub_device == p.dev, p.tag, "sub_device", 32'(sub_device), 32'(p.dev));
          chk(sub_kind == p.kind, p.tag, "sub_kind", 32'(sub_kind), 32'(p.kind));
          if (sub_ready) void'(exp_parts.pop_front());
        end
      end
      if (fault) begin
        chk(!fault_prev, "R8", "fault wider than one cycle", 1, 0);
        if (exp_flts.size() == 0) begin
          chk(0, "R8", "unexpected fault", fault_addr, 0);
        end else begin
          f = exp_flts.pop_front();
          chk(fault_addr == f.addr, f.tag, "fault_addr", fault_addr, f.addr);
          chk(fault_code == f.code, f.tag, "fault_code", 32'(fault_code), 32'(f.code));
        end
      end
      fault_prev = fault;
    end
  end

  // sub_ready pattern, changed just after each edge
  bit stall_mode = 0;
  int stall_cnt  = 0;
  always @(posedge clk) begin
    #1;
    stall_cnt++;
    sub_ready <= stall_mode ? (stall_cnt % 3 == 0) : 1'b1;
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic do_req(input logic [31:0] a, input int sz, input logic [1:0] k,
                        input string tag);
    model(a, sz, k, tag);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = a;
    req_size  = sz[1:0];
    req_kind  = k;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    do @(negedge clk); while (!req_ready);
    chk(exp_parts.size() == 0, tag, "parts not issued", 32'(exp_parts.size()), 0);
    chk(exp_flts.size() == 0, tag, "faults not reported", 32'(exp_flts.size()), 0);
  endtask

  initial begin
    tbl_on = 0;
    for (int i = 0; i < 4; i++) begin
      m_en[i] = 0; m_base[i] = '0; m_lim[i] = '0; m_dev[i] = 0; m_xn[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", 32'(req_ready), 1);
    chk(sub_valid == 1'b0, "R1", "sub_valid in reset", 32'(sub_valid), 0);
    chk(fault == 1'b0, "R1", "fault in reset", 32'(fault), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 1);
    chk(sub_valid == 1'b0, "R1", "sub_valid after reset", 32'(sub_valid), 0);

    // default map only
    do_req(32'h0000_0100, 2, 2'd0, "R2");
    do_req(32'h0000_2000, 2, 2'd2, "R2");
    do_req(32'h0000_0048, 3, 2'd1, "R2");
    do_req(32'h0000_001C, 3, 2'd0, "R3");
    do_req(32'h0000_001F, 1, 2'd1, "R3");
    do_req(32'h0000_0019, 3, 2'd0, "R3");
    do_req(32'h4000_0000, 2, 2'd0, "R7");
    do_req(32'h3FFF_FFF0, 0, 2'd2, "R7");
    do_req(32'h6000_0008, 3, 2'd1, "R8");
    do_req(32'h4000_0002, 2, 2'd0, "R8");
    do_req(32'h5000_0000, 0, 2'd2, "R10");
    do_req(32'h3FFF_FFFC, 3, 2'd0, "R5");
    do_req(32'h3FFF_FFFC, 3, 2'd2, "R5");

    // stalled consumer
    stall_mode = 1;
    do_req(32'h0000_003C, 3, 2'd1, "R11");
    do_req(32'h0000_0400, 3, 2'd0, "R11");
    do_req(32'h0000_007E, 2, 2'd2, "R11");
    stall_mode = 0;

    // table enabled
    m_en[0] = 1; m_base[0] = 27'(32'h2000_0000 >> 5); m_lim[0] = 27'(32'h2000_00FF >> 5);
    m_dev[0] = 1; m_xn[0] = 0;
    m_en[1] = 1; m_base[1] = 27'(32'h2000_0000 >> 5); m_lim[1] = 27'(32'h2FFF_FFFF >> 5);
    m_dev[1] = 0; m_xn[1] = 0;
    m_en[2] = 1; m_base[2] = 27'h7FF_FFFF; m_lim[2] = 27'h7FF_FFFF;
    m_dev[2] = 0; m_xn[2] = 0;
    m_en[3] = 1; m_base[3] = 27'(32'h3000_0000 >> 5); m_lim[3] = 27'(32'h3000_0000 >> 5);
    m_dev[3] = 0; m_xn[3] = 1;
    tbl_on = 1;
    @(negedge clk);

    do_req(32'h2000_0010, 2, 2'd0, "R6");
    do_req(32'h2000_0100, 2, 2'd0, "R6");
    do_req(32'h2000_0010, 2, 2'd2, "R9");
    do_req(32'h1FFF_FFFC, 3, 2'd2, "R9");
    do_req(32'h3000_0000, 2, 2'd2, "R10");
    do_req(32'h2FFF_FFFC, 3, 2'd2, "R10");
    do_req(32'hFFFF_FFFC, 3, 2'd0, "R4");
    do_req(32'hFFFF_FFFA, 2, 2'd2, "R4");
    do_req(32'h2000_00FF, 1, 2'd1, "R8");
    do_req(32'h2000_00FC, 3, 2'd0, "R5");
    m_en[3] = 0;
    @(negedge clk);
    do_req(32'h3000_0000, 2, 2'd2, "R6");
    do_req(32'h5000_0000, 2, 2'd0, "R6");
    tbl_on = 0;
    @(negedge clk);
    do_req(32'h2000_0010, 2, 2'd2, "R7");
    do_req(32'hFFFF_FFFC, 3, 2'd2, "R10");

    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule